// File: doc/BRIEF.md
# Warp Barrier Synchronization Unit

This block keeps the state of a small set of barriers that the warps of a multi-warp core use to meet up. Each request names a barrier, gives the number of warps that must take part, and identifies the warp that is arriving. Each barrier stores its arrivals as a bitmask with one bit per warp. The population count of that mask, taken after the new arrival, is compared with the count carried by the request.

When too few warps have arrived, the unit issues a suspend strobe that names the arriving warp. When the count is met, the unit issues the complete arrival mask as a release vector, which includes the warp that just arrived, and the barrier empties itself so it can be used again. The logic that parks and wakes warps is outside this block. The block has no memory-ordering role.

Top module: `warp_rendezvous`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `suspend_o` is 0 and `release_o` is 0. Reset empties every barrier's arrival mask.
- R2: An arrival sets bit `req_warp_i` only in the arrival mask of barrier `req_bar_i`. No other barrier's mask changes.
- R3: Suppose the population count of the merged mask (the stored mask OR the arriving warp's bit) is below `req_count_i`. Then, one cycle after the request, `suspend_o` is 1, `suspend_warp_o` equals the arriving warp id, and `release_o` is 0.
- R4: Suppose that population count is equal to or greater than `req_count_i`. Then, one cycle after the request, `release_o` equals the merged mask, with bit i set meaning warp i wakes, and `suspend_o` is 0.
- R5: After a barrier releases, its arrival mask is empty. A later arrival on that barrier starts counting again from one.
- R6: A count of 0 or 1 releases immediately, and the arriving warp is never suspended.
- R7: When a warp arrives again at a barrier where its bit is already set, the population count does not grow.
- R8: In a cycle with `req_valid_i` low, the next cycle shows `suspend_o` = 0 and `release_o` = 0, and no barrier state changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | An arrival request is present this cycle |
| req_bar_i | input | BAR_W | Barrier addressed by the request |
| req_count_i | input | CNT_W | Number of warps required, $clog2(NUM_WARPS)+1 bits |
| req_warp_i | input | WARP_W | Id of the arriving warp |
| suspend_o | output | 1 | Registered strobe: the arriving warp must wait |
| suspend_warp_o | output | WARP_W | Warp to suspend, valid while suspend_o is high |
| release_o | output | NUM_WARPS | Registered wake-up vector with one bit per warp |

## Verification
Every result is due exactly one clock edge after its request. A request presented before edge N shows up on `suspend_o`, `suspend_warp_o` and `release_o` just after edge N, with no other latency anywhere in the block. The driver applies a request at a falling edge and pushes the expected tuple, which it computes from its own model of the barrier masks. The monitor samples one time unit after the next rising edge and pops that tuple. When the queue is empty, the monitor instead expects idle outputs. Barrier contents that cannot be seen directly are exposed through later arrivals, whose release vectors show which bits were stored.

// File: rtl/rdv_pkg.sv
package rdv_pkg;
  // Outcome of one arrival, carried between decision and output stage
  typedef enum logic [1:0] {
    RDV_IDLE = 2'd0,
    RDV_HOLD = 2'd1,
    RDV_FREE = 2'd2
  } rdv_outcome_e;
endpackage

// File: rtl/rdv_slot.sv
module rdv_slot #(
  parameter int NUM_WARPS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic                 clear_i,
  input  logic [NUM_WARPS-1:0] load_val_i,
  output logic [NUM_WARPS-1:0] mask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_o <= '0;
    else if (clear_i) mask_o <= '0;
    else if (load_i)  mask_o <= load_val_i;
  end

  // R5
  slot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (mask_o == '0));
  // R2
  slot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> ((mask_o & $past(load_val_i)) == $past(load_val_i)));
  // R8
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !clear_i) |=> $stable(mask_o));
endmodule

// File: rtl/rdv_decide.sv
module rdv_decide #(
  parameter int NUM_WARPS = 4,
  localparam int WARP_W   = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int CNT_W    = $clog2(NUM_WARPS) + 1
) (
  input  logic [NUM_WARPS-1:0] cur_mask_i,
  input  logic [WARP_W-1:0]    warp_i,
  input  logic [CNT_W-1:0]     count_i,
  output logic [NUM_WARPS-1:0] merged_o,
  output logic                 met_o
);
  function automatic logic [CNT_W-1:0] pop_of(input logic [NUM_WARPS-1:0] m);
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < NUM_WARPS; i++) acc = acc + CNT_W'(m[i]);
    return acc;
  endfunction

  logic [NUM_WARPS-1:0] warp_bit;
  logic [CNT_W-1:0]     arrived;

  always_comb begin
    warp_bit         = '0;
    warp_bit[warp_i] = 1'b1;
    merged_o         = cur_mask_i | warp_bit;
    arrived          = pop_of(merged_o);
    met_o            = (arrived >= count_i);
  end
endmodule

// File: rtl/warp_rendezvous.sv
module warp_rendezvous #(
  parameter int NUM_BARRIERS = 4,
  parameter int NUM_WARPS    = 4,
  localparam int BAR_W  = (NUM_BARRIERS > 1) ? $clog2(NUM_BARRIERS) : 1,
  localparam int WARP_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int CNT_W  = $clog2(NUM_WARPS) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid_i,
  input  logic [BAR_W-1:0]     req_bar_i,
  input  logic [CNT_W-1:0]     req_count_i,
  input  logic [WARP_W-1:0]    req_warp_i,
  output logic                 suspend_o,
  output logic [WARP_W-1:0]    suspend_warp_o,
  output logic [NUM_WARPS-1:0] release_o
);
  import rdv_pkg::*;

  logic [NUM_WARPS-1:0] slot_mask [NUM_BARRIERS];
  logic [NUM_WARPS-1:0] cur_mask;
  logic [NUM_WARPS-1:0] merged;
  logic                 met;
  rdv_outcome_e         outcome;

  assign cur_mask = slot_mask[req_bar_i];

  rdv_decide #(.NUM_WARPS(NUM_WARPS)) u_decide (
    .cur_mask_i (cur_mask),
    .warp_i     (req_warp_i),
    .count_i    (req_count_i),
    .merged_o   (merged),
    .met_o      (met)
  );

  always_comb begin
    if (!req_valid_i) outcome = RDV_IDLE;
    else if (met)     outcome = RDV_FREE;
    else              outcome = RDV_HOLD;
  end

  for (genvar g = 0; g < NUM_BARRIERS; g++) begin : g_slot
    logic hit;
    assign hit = req_valid_i && (req_bar_i == BAR_W'(g));
    rdv_slot #(.NUM_WARPS(NUM_WARPS)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (hit && (outcome == RDV_HOLD)),
      .clear_i    (hit && (outcome == RDV_FREE)),
      .load_val_i (merged),
      .mask_o     (slot_mask[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      suspend_o      <= 1'b0;
      suspend_warp_o <= '0;
      release_o      <= '0;
    end else begin
      suspend_o      <= (outcome == RDV_HOLD);
      suspend_warp_o <= req_warp_i;
      release_o      <= (outcome == RDV_FREE) ? merged : '0;
    end
  end

  // R3
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(suspend_o && (release_o != '0)));
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> (!suspend_o && (release_o == '0)));
  // R4
  wake_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (release_o != '0) |-> release_o[$past(req_warp_i)]);
  // R3
  hold_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_o |-> (suspend_warp_o == $past(req_warp_i)));
  // R6
  small_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && (req_count_i <= CNT_W'(1))) |=> !suspend_o);
endmodule

// File: tb/sim_warp_rendezvous.sv
module sim_warp_rendezvous;
  localparam int NB = 4;
  localparam int NW = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_bar = '0;
  logic [2:0] req_count = '0;
  logic [1:0] req_warp = '0;
  logic       suspend;
  logic [1:0] suspend_warp;
  logic [3:0] release_m;

  int checks = 0;
  int fails  = 0;

  logic [6:0] exp_q [$];
  string      tag_q [$];
  logic [3:0] model [NB];

  always #4 clk = ~clk;

  warp_rendezvous #(.NUM_BARRIERS(NB), .NUM_WARPS(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_bar_i(req_bar),
    .req_count_i(req_count), .req_warp_i(req_warp), .suspend_o(suspend),
    .suspend_warp_o(suspend_warp), .release_o(release_m)
  );

  function automatic int ones(input logic [3:0] m);
    int n = 0;
    foreach (m[i]) if (m[i]) n++;
    return n;
  endfunction

  task automatic arrive(input int bar, input int cnt, input int wid, input string tag);
    logic [3:0] nm;
    @(negedge clk);
    req_valid = 1'b1; req_bar = 2'(bar); req_count = 3'(cnt); req_warp = 2'(wid);
    nm = model[bar] | (4'b1 << wid);
    if (ones(nm) < cnt) begin
      model[bar] = nm;
      exp_q.push_back({1'b1, 2'(wid), 4'b0000});
    end else begin
      model[bar] = '0;
      exp_q.push_back({1'b0, 2'b00, nm});
    end
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    foreach (model[i]) model[i] = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // monitor: results are due just after the rising edge that follows a request
  always begin
    @(posedge clk);
    #1;
    if (!rst_n) begin
      checks++;
      if (suspend !== 1'b0 || release_m !== 4'b0) begin
        fails++;
        $display("FAIL R1: got susp=%b rel=%b, expected susp=0 rel=0000", suspend, release_m);
      end
    end else if (exp_q.size() > 0) begin
      logic [6:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (suspend !== e[6] || release_m !== e[3:0] || (e[6] && suspend_warp !== e[5:4])) begin
        fails++;
        $display("FAIL %s: got susp=%b wid=%0d rel=%b, expected susp=%b wid=%0d rel=%b",
                 t, suspend, suspend_warp, release_m, e[6], e[5:4], e[3:0]);
      end
    end else begin
      checks++;
      if (suspend !== 1'b0 || release_m !== 4'b0) begin
        fails++;
        $display("FAIL R8: got susp=%b rel=%b, expected susp=0 rel=0000", suspend, release_m);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none
    foreach (model[i]) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R3 then R4: four warps meet on barrier 0
    arrive(0, 4, 0, "R3");
    arrive(0, 4, 1, "R3");
    arrive(0, 4, 2, "R3");
    arrive(0, 4, 3, "R4");
    idle(2);
    // R5 reuse from empty, R7 repeat arrival does not add
    arrive(0, 2, 1, "R5");
    arrive(0, 2, 1, "R7");
    arrive(0, 2, 2, "R4");
    idle(1);
    // R2 barriers are independent
    arrive(1, 3, 0, "R2");
    arrive(2, 2, 3, "R2");
    arrive(1, 3, 2, "R2");
    arrive(2, 2, 1, "R2");
    arrive(1, 3, 3, "R2");
    idle(2);
    // R6 count one and zero
    arrive(3, 1, 2, "R6");
    arrive(3, 0, 0, "R6");
    idle(1);
    // R4 count exceeded by the arrival
    arrive(0, 3, 0, "R3");
    arrive(0, 3, 1, "R3");
    arrive(0, 2, 2, "R4");
    idle(1);
    // R1 reset empties partially filled barriers
    arrive(3, 3, 1, "R3");
    arrive(3, 3, 0, "R3");
    idle(2);
    do_reset();
    idle(1);
    arrive(3, 2, 2, "R1");
    arrive(3, 2, 3, "R1");
    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule